// File: doc/BRIEF.md
# Multi-Mode ADC Conversion Sequencer

This block is the digital control side of a 10-bit successive-approximation converter. A register-style control write sets a start bit, an interrupt enable, a mode/scan-size select and a channel select. The start bit can also be set by a timer trigger pulse or an external trigger pulse. While the start bit is set, the block runs a binary search. It presents a trial code to an external DAC and reads back one comparator bit per cycle. At the end of each channel's conversion it stores the result in that channel's data register.

Single mode converts the selected channel once. The start bit then clears itself. Scan mode converts a group of four or eight consecutive channels in ascending order. It wraps back to the first channel of the group and keeps running until software clears the start bit. Clearing the start bit during a conversion abandons it. In that case nothing is stored and the block returns to idle.

The sequencer has three states. **S_IDLE** goes to **S_CONV** when the start bit is 1. This loads the search and selects the first channel. **S_CONV** runs one search step per cycle. It moves to **S_WRITE** after the tenth step and returns to **S_IDLE** if the start bit is 0. **S_WRITE** stores the result. From there the block goes to **S_IDLE** in single mode or when the start bit is 0. In scan mode it goes back to **S_CONV** on the next channel of the group.

Top module: `adc_seq`

## Requirements
- R1: Each conversion takes 10 search cycles, deciding bits 9 down to 0 in that order. The trial code `dac_code` is the bits decided so far with the current bit set. A bit is kept when `cmp_hi` is 1, so for an input level v in 0..1023 the stored result equals v.
- R2: Single mode is selected when `ctl_scan[1]` is 0. A control write with `ctl_start`=1 converts channel `ctl_chan` once. `done_flag` rises exactly 12 clock edges after the write edge. At that same point `start_bit` returns to 0 and the result is readable at `rd_data` for that channel.
- R3: A one-cycle pulse on `trig_timer` or on `trig_ext` sets the start bit, and this starts a conversion with the stored mode and channel.
- R4: `done_flag` is set only when a conversion completes (a pass completes in scan mode). It stays set until a control write carries `ctl_done`=0. A control write with `ctl_done`=1 leaves it unchanged.
- R5: `irq` is 1 exactly when `done_flag` is 1 and the stored interrupt enable is 1.
- R6: A control write with `ctl_start`=0 during a conversion stops it. No data register is written, `done_flag` is unchanged and the block goes idle.
- R7: `ctl_scan`=2'b10 scans the four channels starting at `{ctl_chan[3:2],2'b00}` in ascending order. The scan wraps to the group's first channel after the last one.
- R8: `ctl_scan`=2'b11 scans the eight channels starting at channel 0 when `ctl_chan[3]` is 0, or at channel 8 when it is 1, in ascending order.
- R9: In scan mode `start_bit` stays 1 across passes. `done_flag` is set at the end of each full pass and not after a partial pass.
- R10: After reset, `start_bit`, `done_flag` and `irq` are 0 and every data register reads 0.
- R11: A control write that sets the start bit together with a new mode and channel uses them from the first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe; all ctl_* fields are written together |
| ctl_start | input | 1 | Start bit value to write |
| ctl_irq_en | input | 1 | Interrupt enable value to write |
| ctl_scan | input | 2 | 0x single, 10 four-channel scan, 11 eight-channel scan |
| ctl_chan | input | 4 | Channel select (group start bits in scan modes) |
| ctl_done | input | 1 | Writing 0 clears the done flag; 1 leaves it |
| trig_timer | input | 1 | Timer start trigger pulse |
| trig_ext | input | 1 | External start trigger pulse |
| cmp_hi | input | 1 | Comparator: input level is at or above dac_code |
| smp_ch | output | 4 | Channel being converted |
| dac_code | output | 10 | Trial code for the DAC |
| start_bit | output | 1 | Current start bit |
| done_flag | output | 1 | Conversion/pass done flag |
| irq | output | 1 | Interrupt request |
| res_we | output | 1 | Result being stored this cycle |
| res_ch | output | 4 | Channel of the stored result |
| res_data | output | 10 | Value being stored |
| rd_ch | input | 4 | Data register read select |
| rd_data | output | 10 | Data register contents for rd_ch |

## Verification
The hardest conditions to reach from the ports are a wrap in scan mode and a pass boundary. At a wrap, the group restarts and `done_flag` is set without any change to the start bit. The bench reaches this by queueing two full passes of expected results and watching the queue drain. It clears the done flag in the middle of the second pass, so that the second setting of the flag can be seen on its own. It then sends an abort write in the first cycles of a third pass. The abort check itself is timed to land partway through a single conversion. The absence of a write is shown both by the empty scoreboard and by reading the channel's data register back.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_CONV,
        S_WRITE
    } seq_state_t;

    localparam logic [1:0] SCAN_FOUR  = 2'b10;
    localparam logic [1:0] SCAN_EIGHT = 2'b11;
endpackage

// File: rtl/adc_sar_search.sv
module adc_sar_search #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         cmp_hi,
    output logic [W-1:0] trial,
    output logic [W-1:0] code,
    output logic         last
);
    logic [W-1:0] mask_q;
    logic [W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            code_q <= '0;
        end else if (load) begin
            mask_q <= {1'b1, {(W-1){1'b0}}};
            code_q <= '0;
        end else if (step) begin
            if (cmp_hi) code_q <= code_q | mask_q;
            mask_q <= mask_q >> 1;
        end
    end

    assign trial = code_q | mask_q;
    assign code  = code_q;
    assign last  = mask_q[0];

    // R1: only one bit under test at a time
    assert_mask_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int W    = 10,
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [CH_W-1:0] wr_ch,
    input  logic [W-1:0]    wr_data,
    input  logic [CH_W-1:0] rd_ch,
    output logic [W-1:0]    rd_data
);
    localparam int NCH = 1 << CH_W;

    logic [W-1:0] mem [NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_ch] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ch];
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_start,
    input  logic             ctl_irq_en,
    input  logic [1:0]       ctl_scan,
    input  logic [CH_W-1:0]  ctl_chan,
    input  logic             ctl_done,
    input  logic             trig_timer,
    input  logic             trig_ext,
    input  logic             cmp_hi,
    output logic [CH_W-1:0]  smp_ch,
    output logic [RES_W-1:0] dac_code,
    output logic             start_bit,
    output logic             done_flag,
    output logic             irq,
    output logic             res_we,
    output logic [CH_W-1:0]  res_ch,
    output logic [RES_W-1:0] res_data,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data
);
    localparam logic [CH_W-1:0] CH_ONE = 1;

    seq_state_t       state_q, state_d;
    logic             start_q, done_q, ie_q;
    logic [1:0]       scan_q;
    logic [CH_W-1:0]  chan_q, ch_q, ch_d;
    logic             scan_on, trig;
    logic             sar_load, sar_step, sar_last;
    logic             wr_res, pass_end, auto_clr;
    logic [RES_W-1:0] sar_code;

    assign scan_on = scan_q[1];
    assign trig    = trig_timer | trig_ext;

    function automatic logic [CH_W-1:0] first_ch(input logic [1:0] scan,
                                                  input logic [CH_W-1:0] chan);
        unique case (scan)
            SCAN_FOUR:  first_ch = {chan[CH_W-1:2], 2'b00};
            SCAN_EIGHT: first_ch = {chan[CH_W-1:3], 3'b000};
            default:    first_ch = chan;
        endcase
    endfunction

    function automatic logic group_end(input logic [1:0] scan,
                                       input logic [CH_W-1:0] ch);
        unique case (scan)
            SCAN_FOUR:  group_end = (ch[1:0] == 2'b11);
            SCAN_EIGHT: group_end = (ch[2:0] == 3'b111);
            default:    group_end = 1'b1;
        endcase
    endfunction

    adc_sar_search #(.W(RES_W)) u_search (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sar_load),
        .step   (sar_step),
        .cmp_hi (cmp_hi),
        .trial  (dac_code),
        .code   (sar_code),
        .last   (sar_last)
    );

    adc_result_bank #(.W(RES_W), .CH_W(CH_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_res),
        .wr_ch   (ch_q),
        .wr_data (sar_code),
        .rd_ch   (rd_ch),
        .rd_data (rd_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
        end
    end

    // Transitions and per-state outputs
    always_comb begin
        state_d  = state_q;
        ch_d     = ch_q;
        sar_load = 1'b0;
        sar_step = 1'b0;
        wr_res   = 1'b0;
        pass_end = 1'b0;
        auto_clr = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_q) begin
                    state_d  = S_CONV;
                    ch_d     = first_ch(scan_q, chan_q);
                    sar_load = 1'b1;
                end
            end
            S_CONV: begin
                if (!start_q) begin
                    state_d = S_IDLE;
                end else begin
                    sar_step = 1'b1;
                    if (sar_last) state_d = S_WRITE;
                end
            end
            S_WRITE: begin
                if (!start_q) begin
                    state_d = S_IDLE;
                end else begin
                    wr_res = 1'b1;
                    if (!scan_on) begin
                        auto_clr = 1'b1;
                        pass_end = 1'b1;
                        state_d  = S_IDLE;
                    end else begin
                        sar_load = 1'b1;
                        state_d  = S_CONV;
                        if (group_end(scan_q, ch_q)) begin
                            pass_end = 1'b1;
                            ch_d     = first_ch(scan_q, chan_q);
                        end else begin
                            ch_d = ch_q + CH_ONE;
                        end
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Control register: write beats trigger, trigger beats self-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            ie_q    <= 1'b0;
            scan_q  <= 2'b00;
            chan_q  <= '0;
        end else begin
            if (ctl_we)        start_q <= ctl_start;
            else if (trig)     start_q <= 1'b1;
            else if (auto_clr) start_q <= 1'b0;

            if (pass_end)                done_q <= 1'b1;
            else if (ctl_we && !ctl_done) done_q <= 1'b0;

            if (ctl_we) begin
                ie_q   <= ctl_irq_en;
                scan_q <= ctl_scan;
                chan_q <= ctl_chan;
            end
        end
    end

    assign smp_ch    = ch_q;
    assign start_bit = start_q;
    assign done_flag = done_q;
    assign irq       = done_q & ie_q;
    assign res_we    = wr_res;
    assign res_ch    = ch_q;
    assign res_data  = sar_code;

    assert_done_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(state_q) == S_WRITE);

    assert_abort_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV && !start_q) |=> state_q == S_IDLE);

    assert_single_self_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && start_q && !scan_on && !ctl_we && !trig) |=> !start_q);

    assert_four_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && scan_q == SCAN_FOUR && !$past(ctl_we))
            |-> ch_q[CH_W-1:2] == chan_q[CH_W-1:2]);

    assert_eight_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && scan_q == SCAN_EIGHT && !$past(ctl_we))
            |-> ch_q[CH_W-1:3] == chan_q[CH_W-1:3]);
endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0, ctl_start = 1'b0, ctl_irq_en = 1'b0, ctl_done = 1'b1;
    logic [1:0] ctl_scan = 2'b00;
    logic [3:0] ctl_chan = 4'd0;
    logic       trig_timer = 1'b0, trig_ext = 1'b0;
    logic       cmp_hi;
    logic [3:0] smp_ch, res_ch;
    logic [3:0] rd_ch = 4'd0;
    logic [9:0] dac_code, res_data, rd_data;
    logic       start_bit, done_flag, irq, res_we;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    logic [9:0] ana [16];

    typedef struct packed {
        logic [3:0] ch;
        logic [9:0] val;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    adc_seq u_adc_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
        .ctl_irq_en(ctl_irq_en), .ctl_scan(ctl_scan), .ctl_chan(ctl_chan),
        .ctl_done(ctl_done), .trig_timer(trig_timer), .trig_ext(trig_ext),
        .cmp_hi(cmp_hi), .smp_ch(smp_ch), .dac_code(dac_code),
        .start_bit(start_bit), .done_flag(done_flag), .irq(irq),
        .res_we(res_we), .res_ch(res_ch), .res_data(res_data),
        .rd_ch(rd_ch), .rd_data(rd_data)
    );

    // Abstract comparator: analog level per channel vs trial code
    always_comb cmp_hi = (ana[smp_ch] >= dac_code);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Monitor: compare every stored result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_we) begin
            if (q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL %s unexpected store actual=%0h expected=none", cur_req, res_ch);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cur_req, "store channel", res_ch, e.ch);
                check("R1", "store value", res_data, e.val);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    task automatic ctl_write(input logic st, input logic ie, input logic [1:0] sc,
                             input logic [3:0] ch, input logic dn);
        @(negedge clk);
        ctl_we = 1'b1; ctl_start = st; ctl_irq_en = ie;
        ctl_scan = sc; ctl_chan = ch; ctl_done = dn;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic push(input logic [3:0] ch);
        q.push_back({ch, ana[ch]});
    endtask

    task automatic wait_q(input int n);
        while (q.size() != n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic read_reg(input string req, input logic [3:0] ch, input logic [9:0] exp);
        rd_ch = ch;
        #1;
        check(req, "data register", rd_data, exp);
    endtask

    task automatic run_single(input string req, input logic [3:0] ch, input logic ie);
        cur_req = req;
        push(ch);
        ctl_write(1'b1, ie, 2'b00, ch, 1'b0);
        repeat (11) @(negedge clk);
        check(req, "done before 12th edge", done_flag, 1'b0);
        @(negedge clk);
        check(req, "done at 12th edge", done_flag, 1'b1);
        check(req, "start self-cleared", start_bit, 1'b0);
        check(req, "scoreboard drained", q.size(), 0);
        read_reg(req, ch, ana[ch]);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) ana[i] = 10'((i * 67 + 13) % 1024);
        ana[0] = 10'd0; ana[15] = 10'd1023; ana[10] = 10'd512;
        ana[11] = 10'd511; ana[5] = 10'h2A7; ana[9] = 10'd100;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10", "start", start_bit, 1'b0);
        check("R10", "done", done_flag, 1'b0);
        check("R10", "irq", irq, 1'b0);
        for (int i = 0; i < 16; i += 5) read_reg("R10", 4'(i), 10'd0);

        // R2 single conversion, R5 irq with enable
        run_single("R2", 4'd5, 1'b1);
        check("R5", "irq enabled", irq, 1'b1);

        // R1 corner levels
        run_single("R1", 4'd0, 1'b0);
        run_single("R1", 4'd15, 1'b0);
        run_single("R1", 4'd10, 1'b0);
        run_single("R1", 4'd11, 1'b0);
        check("R5", "irq disabled", irq, 1'b0);

        // R4 done hold / clear, R5 gating
        ctl_write(1'b0, 1'b0, 2'b00, 4'd11, 1'b1);
        check("R4", "done kept by write of 1", done_flag, 1'b1);
        ctl_write(1'b0, 1'b1, 2'b00, 4'd11, 1'b1);
        check("R5", "irq after enable", irq, 1'b1);
        ctl_write(1'b0, 1'b1, 2'b00, 4'd11, 1'b0);
        check("R4", "done cleared by write of 0", done_flag, 1'b0);
        check("R5", "irq after clear", irq, 1'b0);

        // R3 timer trigger
        cur_req = "R3";
        ctl_write(1'b0, 1'b0, 2'b00, 4'd3, 1'b0);
        push(4'd3);
        @(negedge clk); trig_timer = 1'b1;
        @(negedge clk); trig_timer = 1'b0;
        repeat (12) @(negedge clk);
        check("R3", "timer done", done_flag, 1'b1);
        check("R3", "timer start cleared", start_bit, 1'b0);
        read_reg("R3", 4'd3, ana[3]);

        // R3 external trigger
        ctl_write(1'b0, 1'b0, 2'b00, 4'd7, 1'b0);
        push(4'd7);
        @(negedge clk); trig_ext = 1'b1;
        @(negedge clk); trig_ext = 1'b0;
        repeat (12) @(negedge clk);
        check("R3", "ext done", done_flag, 1'b1);
        read_reg("R3", 4'd7, ana[7]);

        // R6 abort mid-conversion
        cur_req = "R6";
        ctl_write(1'b1, 1'b0, 2'b00, 4'd9, 1'b0);
        repeat (4) @(negedge clk);
        ctl_write(1'b0, 1'b0, 2'b00, 4'd9, 1'b1);
        repeat (20) @(negedge clk);
        check("R6", "start after abort", start_bit, 1'b0);
        check("R6", "done after abort", done_flag, 1'b0);
        read_reg("R6", 4'd9, 10'd0);

        // R7 four-channel scan, group 4..7, two passes with wrap; R9 pass flag
        cur_req = "R7";
        for (int p = 0; p < 2; p++) for (int c = 4; c < 8; c++) push(4'(c));
        ctl_write(1'b1, 1'b1, 2'b10, 4'b0110, 1'b0);
        wait_q(5);
        check("R9", "done not after partial pass", done_flag, 1'b0);
        wait_q(4);
        @(negedge clk);
        check("R9", "done after first pass", done_flag, 1'b1);
        check("R9", "start held in scan", start_bit, 1'b1);
        ctl_write(1'b1, 1'b1, 2'b10, 4'b0110, 1'b0);
        check("R9", "done cleared mid pass", done_flag, 1'b0);
        wait_q(0);
        @(negedge clk);
        check("R9", "done after second pass", done_flag, 1'b1);
        ctl_write(1'b0, 1'b1, 2'b10, 4'b0110, 1'b1);
        repeat (15) @(negedge clk);
        check("R6", "scan stopped", start_bit, 1'b0);
        read_reg("R7", 4'd6, ana[6]);

        // R8 eight-channel scans, upper and lower groups
        cur_req = "R8";
        for (int c = 8; c < 16; c++) push(4'(c));
        ctl_write(1'b1, 1'b0, 2'b11, 4'b1010, 1'b0);
        wait_q(0);
        @(negedge clk);
        check("R8", "done after upper pass", done_flag, 1'b1);
        ctl_write(1'b0, 1'b0, 2'b11, 4'b1010, 1'b0);
        repeat (15) @(negedge clk);
        for (int c = 0; c < 8; c++) push(4'(c));
        ctl_write(1'b1, 1'b0, 2'b11, 4'b0111, 1'b0);
        wait_q(0);
        @(negedge clk);
        check("R8", "done after lower pass", done_flag, 1'b1);
        ctl_write(1'b0, 1'b0, 2'b11, 4'b0111, 1'b0);
        repeat (15) @(negedge clk);
        check("R8", "scan stopped", start_bit, 1'b0);

        // R11 new mode and channel written with start, scan=01 is single
        cur_req = "R11";
        ana[2] = 10'd777;
        push(4'd2);
        ctl_write(1'b1, 1'b0, 2'b01, 4'd2, 1'b0);
        repeat (12) @(negedge clk);
        check("R11", "single after scan", start_bit, 1'b0);
        check("R11", "done", done_flag, 1'b1);
        check("R11", "scoreboard drained", q.size(), 0);
        read_reg("R11", 4'd2, 10'd777);

        repeat (5) @(negedge clk);
        check("R11", "no stray stores", q.size(), 0);
        report();
    end
endmodule